// File: doc/BRIEF.md
# PUF Response Quality Metrics Engine

This block gathers 128-bit responses read from physically unclonable function cells on a population of chips. It computes the quality figures used to judge such a population, all in unsigned fixed point. Each accepted response goes into one of two on-chip slots for its chip: a nominal slot or a stressed slot. The slot is picked by a tag that arrives with the data. The number of ones in each accepted response is reported one cycle later.

When software raises `start`, the engine makes one pass over the stored data. It visits every unordered pair of stored nominal responses to gather the inter-chip Hamming distances. In the same pass it visits every chip once, to count ones per bit position (aliasing) and to measure the distance between each chip's nominal and stressed readings (reliability). One XOR-and-popcount is evaluated per cycle. The two averages are then formed by a shared sequential divider, and `done` pulses once all results are final.

Results carry `FRAC_W` fractional bits, so 1.0 is `1 << FRAC_W`. A population with fewer than two nominal chips raises an error flag and reports zero uniqueness.

Top module: `puf_metrics_engine`

## Requirements
- R1: `in_ready` is high exactly while the engine is idle. A response accepted (`in_valid && in_ready`) is stored in chip slot `in_chip`: the stressed slot when `in_stressed` is 1, the nominal slot when it is 0. A later write to the same slot replaces the earlier one. Responses offered while busy are not stored.
- R2: One cycle after each accepted response, `ones_valid` is 1 and `ones_count` holds the number of ones in that response. `ones_valid` is 0 in every other cycle.
- R3: `start` while idle makes `busy` high from the next cycle. `start` while busy has no effect. Every accumulator is cleared at start, so starting twice over unchanged storage gives identical results.
- R4: Let m be the number of chips with a stored nominal response, P = m(m-1)/2, and S the sum of Hamming distances (popcount of XOR) over all pairs of them. Then `uniq_q` = floor(S * 2^FRAC_W / (P * 128)).
- R5: `hd_min` and `hd_max` are the smallest and largest pairwise Hamming distance among the stored nominal responses. Both are 0 when no pair exists.
- R6: After `done`, `alias_q` is combinational in `alias_sel`. It equals floor(c * 2^FRAC_W / m), where c is the number of stored nominal responses with a 1 at bit `alias_sel`. It is 0 when m = 0.
- R7: Let k be the number of chips holding both a nominal and a stressed response, and D the sum of their nominal-to-stressed Hamming distances. Then `rel_q` = floor((128k - D) * 2^FRAC_W / (128k)), and `rel_q` is 0 when k = 0.
- R8: `done` is a single-cycle pulse, high only when all results are final. Results then hold their values until the next start.
- R9: When m < 2 at the end of the pass, `error` is 1 and `uniq_q`, `hd_min` and `hd_max` are 0. Otherwise `error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Response offered |
| in_ready | output | 1 | Engine can take a response |
| in_data | input | RESP_W | Response bits |
| in_stressed | input | 1 | 1 for the stressed slot, 0 for the nominal slot |
| in_chip | input | log2(MAX_CHIPS) | Chip slot index |
| ones_valid | output | 1 | Ones count of the last accepted response is valid |
| ones_count | output | log2(RESP_W)+1 | Number of ones in that response |
| start | input | 1 | Begin an evaluation pass |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse, all results final |
| error | output | 1 | Fewer than two nominal chips stored |
| uniq_q | output | FRAC_W+1 | Uniqueness, fixed point |
| rel_q | output | FRAC_W+1 | Reliability, fixed point |
| hd_min | output | log2(RESP_W)+1 | Smallest pairwise distance |
| hd_max | output | log2(RESP_W)+1 | Largest pairwise distance |
| alias_sel | input | log2(RESP_W) | Bit position for the aliasing readout |
| alias_q | output | FRAC_W+1 | Aliasing of the selected bit, fixed point |

## Verification
Faults in the pair walk or in the storage slots cannot be seen until `done`. At that point a skipped or repeated pair shows up in `uniq_q`, `hd_min` or `hd_max`. A nominal and stressed slot swapped or mixed up shows in `rel_q`, and a mis-gated bit counter shows in `alias_q` at the first bit position read back. A stale accumulator that a start fails to clear makes the second of two identical runs differ from the first. The ones-count path is compared on every clock, so a latency or gating error there shows one cycle after the offending beat.

// File: rtl/puf_metrics_pkg.sv
package puf_metrics_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PASS,
      ST_PREP_U,
      ST_DIV_U,
      ST_PREP_R,
      ST_DIV_R,
      ST_FIN
   } eng_state_t;

endpackage

// File: rtl/puf_popcount.sv
module puf_popcount #(
   parameter int W     = 128,
   parameter int CHUNK = 8
) (
   input  logic [W-1:0]         vec,
   output logic [$clog2(W):0]   cnt
);
   localparam int OW  = $clog2(W) + 1;
   localparam int CW  = $clog2(CHUNK) + 1;
   localparam int NCH = W / CHUNK;

   function automatic logic [CW-1:0] chunk_ones(input logic [CHUNK-1:0] v);
      logic [CW-1:0] s;
      s = '0;
      for (int i = 0; i < CHUNK; i++) s = s + CW'(v[i]);
      return s;
   endfunction

   generate
      if (W % CHUNK == 0 && NCH > 1) begin : g_chunked
         logic [NCH*CW-1:0] parts;
         for (genvar g = 0; g < NCH; g++) begin : g_part
            assign parts[g*CW +: CW] = chunk_ones(vec[g*CHUNK +: CHUNK]);
         end
         always_comb begin
            cnt = '0;
            for (int g = 0; g < NCH; g++) cnt = cnt + OW'(parts[g*CW +: CW]);
         end
      end else begin : g_flat
         always_comb begin
            cnt = '0;
            for (int i = 0; i < W; i++) cnt = cnt + OW'(vec[i]);
         end
      end
   endgenerate

endmodule

// File: rtl/puf_pair_walk.sv
module puf_pair_walk #(
   parameter int N = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   advance,
   output logic [$clog2(N)-1:0]   p,
   output logic [$clog2(N):0]     q,
   output logic                   row,
   output logic                   last
);
   localparam int PW = $clog2(N);
   localparam int QW = PW + 1;

   // q runs p+1 .. N; the q == N slot is the per-chip row cycle
   assign row  = (q == QW'(N));
   assign last = row && (p == PW'(N - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p <= '0;
         q <= QW'(1);
      end else if (clear) begin
         p <= '0;
         q <= QW'(1);
      end else if (advance) begin
         if (row) begin
            p <= p + PW'(1);
            q <= QW'(p) + QW'(2);
         end else begin
            q <= q + QW'(1);
         end
      end
   end

endmodule

// File: rtl/puf_seq_div.sv
module puf_seq_div #(
   parameter int W = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [W-1:0]  num,
   input  logic [W-1:0]  den,
   output logic          done,
   output logic [W-1:0]  quo
);
   localparam int CW = $clog2(W + 1);

   logic          run;
   logic [CW-1:0] cnt;
   logic [W-1:0]  rem, nsh, den_r;
   logic [W:0]    trial;
   logic          fits;

   assign trial = {rem, nsh[W-1]};
   assign fits  = (trial >= {1'b0, den_r});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         cnt   <= '0;
         rem   <= '0;
         nsh   <= '0;
         den_r <= '0;
         quo   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            run   <= 1'b1;
            cnt   <= CW'(W);
            rem   <= '0;
            nsh   <= num;
            den_r <= den;
            quo   <= '0;
         end else if (run) begin
            if (fits) rem <= W'(trial - {1'b0, den_r});
            else      rem <= trial[W-1:0];
            quo <= {quo[W-2:0], fits};
            nsh <= nsh << 1;
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/puf_metrics_engine.sv
module puf_metrics_engine
   import puf_metrics_pkg::*;
#(
   parameter int RESP_W    = 128,
   parameter int MAX_CHIPS = 8,
   parameter int FRAC_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [RESP_W-1:0]             in_data,
   input  logic                          in_stressed,
   input  logic [$clog2(MAX_CHIPS)-1:0]  in_chip,
   output logic                          ones_valid,
   output logic [$clog2(RESP_W):0]       ones_count,
   input  logic                          start,
   output logic                          busy,
   output logic                          done,
   output logic                          error,
   output logic [FRAC_W:0]               uniq_q,
   output logic [FRAC_W:0]               rel_q,
   output logic [$clog2(RESP_W):0]       hd_min,
   output logic [$clog2(RESP_W):0]       hd_max,
   input  logic [$clog2(RESP_W)-1:0]     alias_sel,
   output logic [FRAC_W:0]               alias_q
);
   localparam int LW     = $clog2(RESP_W);
   localparam int HDW    = LW + 1;
   localparam int CHIP_W = $clog2(MAX_CHIPS);
   localparam int QW     = CHIP_W + 1;
   localparam int NPAIRS = MAX_CHIPS * (MAX_CHIPS - 1) / 2;
   localparam int PAIR_W = $clog2(NPAIRS + 1);
   localparam int SUM_W  = $clog2((NPAIRS + MAX_CHIPS) * RESP_W + 1);
   localparam int DIV_W  = SUM_W + FRAC_W;
   localparam int ACNT_W = $clog2(MAX_CHIPS + 1);
   localparam int QO_W   = FRAC_W + 1;
   localparam int AN_W   = ACNT_W + FRAC_W;

   generate
      if (RESP_W < 8 || (1 << LW) != RESP_W) begin : g_bad_width
         $error("RESP_W must be a power of two of at least 8");
      end
      if (MAX_CHIPS < 2 || (1 << CHIP_W) != MAX_CHIPS) begin : g_bad_chips
         $error("MAX_CHIPS must be a power of two of at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("FRAC_W must be at least 1");
      end
   endgenerate

   eng_state_t st;
   logic start_go, in_pass;

   assign busy     = (st != ST_IDLE);
   assign in_ready = !busy;
   assign done     = (st == ST_FIN);
   assign start_go = start && (st == ST_IDLE);
   assign in_pass  = (st == ST_PASS);

   // ---------------- response storage ----------------
   logic [RESP_W-1:0]    nom_mem [MAX_CHIPS];
   logic [RESP_W-1:0]    str_mem [MAX_CHIPS];
   logic [MAX_CHIPS-1:0] nom_vld, str_vld;
   logic                 wr_en;

   assign wr_en = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (in_stressed) str_mem[in_chip] <= in_data;
         else             nom_mem[in_chip] <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nom_vld <= '0;
         str_vld <= '0;
      end else if (wr_en) begin
         if (in_stressed) str_vld[in_chip] <= 1'b1;
         else             nom_vld[in_chip] <= 1'b1;
      end
   end

   // ---------------- ones count of incoming responses ----------------
   logic [HDW-1:0] in_ones;

   puf_popcount #(.W(RESP_W)) u_pc_in (.vec(in_data), .cnt(in_ones));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_valid <= 1'b0;
         ones_count <= '0;
      end else begin
         ones_valid <= wr_en;
         if (wr_en) ones_count <= in_ones;
      end
   end

   // ---------------- pair walk and distance unit ----------------
   logic [CHIP_W-1:0] wp;
   logic [QW-1:0]     wq;
   logic              w_row, w_last;
   logic [CHIP_W-1:0] wq_idx;
   logic [RESP_W-1:0] opnd_a, opnd_b;
   logic [HDW-1:0]    hd;
   logic              pair_ok, row_nom, row_both;

   puf_pair_walk #(.N(MAX_CHIPS)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_go),
      .advance (in_pass),
      .p       (wp),
      .q       (wq),
      .row     (w_row),
      .last    (w_last)
   );

   assign wq_idx   = wq[CHIP_W-1:0];
   assign opnd_a   = nom_mem[wp];
   assign opnd_b   = w_row ? str_mem[wp] : nom_mem[wq_idx];
   assign pair_ok  = in_pass && !w_row && nom_vld[wp] && nom_vld[wq_idx];
   assign row_nom  = in_pass && w_row && nom_vld[wp];
   assign row_both = row_nom && str_vld[wp];

   puf_popcount #(.W(RESP_W)) u_pc_hd (.vec(opnd_a ^ opnd_b), .cnt(hd));

   // ---------------- accumulators ----------------
   logic [SUM_W-1:0]  sum_hd, rel_sum;
   logic [PAIR_W-1:0] npairs;
   logic [ACNT_W-1:0] m_cnt, k_cnt;
   logic [HDW-1:0]    min_r, max_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_hd  <= '0;
         rel_sum <= '0;
         npairs  <= '0;
         m_cnt   <= '0;
         k_cnt   <= '0;
         min_r   <= HDW'(RESP_W);
         max_r   <= '0;
      end else if (start_go) begin
         sum_hd  <= '0;
         rel_sum <= '0;
         npairs  <= '0;
         m_cnt   <= '0;
         k_cnt   <= '0;
         min_r   <= HDW'(RESP_W);
         max_r   <= '0;
      end else begin
         if (pair_ok) begin
            sum_hd <= sum_hd + SUM_W'(hd);
            npairs <= npairs + PAIR_W'(1);
            if (hd < min_r) min_r <= hd;
            if (hd > max_r) max_r <= hd;
         end
         if (row_nom)  m_cnt <= m_cnt + ACNT_W'(1);
         if (row_both) begin
            k_cnt   <= k_cnt + ACNT_W'(1);
            rel_sum <= rel_sum + SUM_W'(hd);
         end
      end
   end

   // per-bit aliasing counters
   logic [RESP_W*ACNT_W-1:0] alias_flat;

   generate
      for (genvar i = 0; i < RESP_W; i++) begin : g_alias
         logic [ACNT_W-1:0] cnt_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_r <= '0;
            else if (start_go)               cnt_r <= '0;
            else if (row_nom && opnd_a[i])   cnt_r <= cnt_r + ACNT_W'(1);
         end
         assign alias_flat[i*ACNT_W +: ACNT_W] = cnt_r;
      end
   endgenerate

   logic [ACNT_W-1:0] sel_cnt;
   logic [AN_W-1:0]   a_num, a_quo;

   assign sel_cnt = alias_flat[alias_sel*ACNT_W +: ACNT_W];
   assign a_num   = {sel_cnt, {FRAC_W{1'b0}}};
   assign a_quo   = (m_cnt == '0) ? '0 : a_num / AN_W'(m_cnt);
   assign alias_q = QO_W'(a_quo);

   // ---------------- shared divider ----------------
   logic [DIV_W-1:0] u_num, u_den, k_bits, r_num, div_num, div_den, div_quo;
   logic             div_go, div_done;

   assign u_num   = DIV_W'(sum_hd) << FRAC_W;
   assign u_den   = DIV_W'(npairs) << LW;
   assign k_bits  = DIV_W'(k_cnt) << LW;
   assign r_num   = (k_bits - DIV_W'(rel_sum)) << FRAC_W;
   assign div_num = (st == ST_PREP_R) ? r_num  : u_num;
   assign div_den = (st == ST_PREP_R) ? k_bits : u_den;
   assign div_go  = ((st == ST_PREP_U) && (npairs != '0)) ||
                    ((st == ST_PREP_R) && (k_cnt  != '0));

   puf_seq_div #(.W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .done  (div_done),
      .quo   (div_quo)
   );

   // ---------------- sequencing and result registers ----------------
   logic [QO_W-1:0] uniq_r, rel_r;
   logic            err_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         uniq_r <= '0;
         rel_r  <= '0;
         err_r  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st     <= ST_PASS;
               uniq_r <= '0;
               rel_r  <= '0;
               err_r  <= 1'b0;
            end
            ST_PASS:   if (w_last) st <= ST_PREP_U;
            ST_PREP_U: begin
               err_r <= (m_cnt < ACNT_W'(2));
               st    <= (npairs != '0) ? ST_DIV_U : ST_PREP_R;
            end
            ST_DIV_U: if (div_done) begin
               uniq_r <= QO_W'(div_quo);
               st     <= ST_PREP_R;
            end
            ST_PREP_R: st <= (k_cnt != '0) ? ST_DIV_R : ST_FIN;
            ST_DIV_R: if (div_done) begin
               rel_r <= QO_W'(div_quo);
               st    <= ST_FIN;
            end
            ST_FIN:    st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign error  = err_r;
   assign uniq_q = uniq_r;
   assign rel_q  = rel_r;
   assign hd_min = (npairs == '0) ? '0 : min_r;
   assign hd_max = max_r;

endmodule

// File: rtl/puf_metrics_sva.sv
module puf_metrics_sva #(
   parameter int RESP_W = 128,
   parameter int FRAC_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic                    start,
   input logic                    busy,
   input logic                    done,
   input logic                    error,
   input logic                    ones_valid,
   input logic [$clog2(RESP_W):0] ones_count,
   input logic [FRAC_W:0]         uniq_q,
   input logic [FRAC_W:0]         rel_q,
   input logic [$clog2(RESP_W):0] hd_min,
   input logic [$clog2(RESP_W):0] hd_max
);
   localparam int ONE_Q = 1 << FRAC_W;

   AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !ones_valid);                        // R1
   AST_ONES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> ones_valid);                        // R2
   AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ones_valid |-> (ones_count <= ($clog2(RESP_W)+1)'(RESP_W)));   // R2
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                    // R3
   AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (uniq_q <= (FRAC_W+1)'(ONE_Q) && rel_q <= (FRAC_W+1)'(ONE_Q))); // R4
   AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !error) |-> (hd_min <= hd_max));                      // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                               // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> ($stable(uniq_q) && $stable(rel_q) && $stable(hd_max))); // R8
   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && error) |-> (uniq_q == '0 && hd_min == '0 && hd_max == '0)); // R9

endmodule

bind puf_metrics_engine puf_metrics_sva #(.RESP_W(RESP_W), .FRAC_W(FRAC_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .error      (error),
   .ones_valid (ones_valid),
   .ones_count (ones_count),
   .uniq_q     (uniq_q),
   .rel_q      (rel_q),
   .hd_min     (hd_min),
   .hd_max     (hd_max)
);

// File: tb/puf_metrics_engine_tb.sv
`timescale 1ns/1ps
module puf_metrics_engine_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic         in_stressed = 1'b0;
   logic [2:0]   in_chip = '0;
   logic         ones_valid;
   logic [7:0]   ones_count;
   logic         start = 1'b0;
   logic         busy, done, error;
   logic [8:0]   uniq_q, rel_q, alias_q;
   logic [7:0]   hd_min, hd_max;
   logic [6:0]   alias_sel = '0;

   always #2 clk = ~clk;

   puf_metrics_engine u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_stressed(in_stressed), .in_chip(in_chip),
      .ones_valid(ones_valid), .ones_count(ones_count), .start(start),
      .busy(busy), .done(done), .error(error), .uniq_q(uniq_q), .rel_q(rel_q),
      .hd_min(hd_min), .hd_max(hd_max), .alias_sel(alias_sel), .alias_q(alias_q)
   );

   int tests = 0;
   int fails = 0;
   bit tb_busy = 1'b0;

   // behavioural model of the stored population
   logic [127:0] m_nom [8];
   logic [127:0] m_str [8];
   bit           m_nv  [8];
   bit           m_sv  [8];

   longint e_uniq, e_rel, e_min, e_max;
   bit     e_err;
   int     e_m;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int pc(input logic [127:0] v);
      int c = 0;
      for (int i = 0; i < 128; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic [127:0] rnd();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // ones-count path compared every clock
   bit mon_acc = 1'b0;
   int mon_ones = 0;
   always @(posedge clk) begin
      mon_acc  <= rst_n && in_valid && !tb_busy;
      mon_ones <= pc(in_data);
   end
   always @(negedge clk) begin
      if (rst_n) begin
         chk(ones_valid === mon_acc, "R2", "ones_valid", longint'(ones_valid), longint'(mon_acc));
         if (mon_acc) chk(int'(ones_count) == mon_ones, "R2", "ones_count",
                          longint'(ones_count), longint'(mon_ones));
      end
   end

   task automatic send(input int chip, input bit stressed, input logic [127:0] d);
      @(negedge clk);
      in_valid    = 1'b1;
      in_chip     = 3'(chip);
      in_stressed = stressed;
      in_data     = d;
      chk(in_ready === 1'b1, "R1", "in_ready idle", longint'(in_ready), 1);
      if (stressed) begin m_str[chip] = d; m_sv[chip] = 1'b1; end
      else          begin m_nom[chip] = d; m_nv[chip] = 1'b1; end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic compute_expect();
      longint s = 0, np = 0, rs = 0, k = 0;
      e_m = 0; e_min = 128; e_max = 0;
      for (int p = 0; p < 8; p++) begin
         if (m_nv[p]) begin
            e_m++;
            if (m_sv[p]) begin k++; rs += pc(m_nom[p] ^ m_str[p]); end
            for (int q = p + 1; q < 8; q++) begin
               if (m_nv[q]) begin
                  int h = pc(m_nom[p] ^ m_nom[q]);
                  np++; s += h;
                  if (h < e_min) e_min = h;
                  if (h > e_max) e_max = h;
               end
            end
         end
      end
      if (np == 0) begin e_min = 0; e_max = 0; end
      e_uniq = (np != 0) ? (s * 256) / (np * 128) : 0;
      e_rel  = (k != 0) ? ((k * 128 - rs) * 256) / (k * 128) : 0;
      e_err  = (e_m < 2);
   endtask

   function automatic longint exp_alias(input int idx);
      int c = 0;
      for (int p = 0; p < 8; p++) if (m_nv[p] && m_nom[p][idx]) c++;
      return (e_m != 0) ? (longint'(c) * 256) / e_m : 0;
   endfunction

   task automatic run_pass(input bit disturb);
      int n = 0;
      bit seen = 1'b0;
      compute_expect();
      @(negedge clk);
      start = 1'b1;
      tb_busy = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R3", "busy after start", longint'(busy), 1);
      chk(in_ready === 1'b0, "R1", "in_ready while busy", longint'(in_ready), 0);
      while (!seen && n < 3000) begin
         if (disturb && n == 5) begin
            start = 1'b1; in_valid = 1'b1; in_chip = 3'd1;
            in_stressed = 1'b0; in_data = '1;
         end else begin
            start = 1'b0; in_valid = 1'b0;
         end
         @(negedge clk);
         n++;
         if (done === 1'b1) seen = 1'b1;
      end
      start = 1'b0; in_valid = 1'b0;
      if (!seen) begin
         tests++; fails++;
         $display("FAIL R8 done never seen: actual 0 expected 1");
      end else begin
         chk(uniq_q == 9'(e_uniq), "R4", "uniqueness", longint'(uniq_q), e_uniq);
         chk(hd_min == 8'(e_min), "R5", "min distance", longint'(hd_min), e_min);
         chk(hd_max == 8'(e_max), "R5", "max distance", longint'(hd_max), e_max);
         chk(rel_q == 9'(e_rel), "R7", "reliability", longint'(rel_q), e_rel);
         chk(error == e_err, "R9", "error flag", longint'(error), longint'(e_err));
         @(negedge clk);
         chk(done === 1'b0, "R8", "done single cycle", longint'(done), 0);
         tb_busy = 1'b0;
         @(negedge clk);
         chk(uniq_q == 9'(e_uniq), "R8", "uniqueness held", longint'(uniq_q), e_uniq);
      end
      tb_busy = 1'b0;
   endtask

   task automatic check_alias(input int idx);
      @(negedge clk);
      alias_sel = 7'(idx);
      @(negedge clk);
      chk(alias_q == 9'(exp_alias(idx)), "R6", $sformatf("aliasing bit %0d", idx),
          longint'(alias_q), exp_alias(idx));
   endtask

   initial begin
      #(4.0 * 150000);
      tests++; fails++;
      $display("FAIL watchdog expired: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [127:0] shared;
      for (int i = 0; i < 8; i++) begin m_nv[i] = 0; m_sv[i] = 0; m_nom[i] = '0; m_str[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(busy === 1'b0, "R3", "busy at reset", longint'(busy), 0);
      chk(done === 1'b0, "R8", "done at reset", longint'(done), 0);
      chk(in_ready === 1'b1, "R1", "in_ready at reset", longint'(in_ready), 1);
      chk(error === 1'b0, "R9", "error at reset", longint'(error), 0);
      chk(uniq_q == 9'd0, "R4", "uniqueness at reset", longint'(uniq_q), 0);

      // single chip: error case, all-ones ones count
      send(3, 1'b0, '1);
      run_pass(1'b0);
      check_alias(5);

      // sparse population with partial stressed readings
      send(1, 1'b0, rnd());
      send(2, 1'b0, rnd());
      send(4, 1'b0, rnd());
      send(6, 1'b0, rnd());
      send(1, 1'b1, m_nom[1] ^ 128'h7);
      send(2, 1'b1, m_nom[2] ^ {118'd0, 10'h3FF});
      send(5, 1'b1, rnd());
      send(0, 1'b1, '0);
      run_pass(1'b0);
      check_alias(0);
      check_alias(63);
      check_alias(127);

      // repeat with disturbance: results unchanged, extra start/write ignored
      run_pass(1'b1);
      check_alias(64);

      // full population with extremes
      shared = rnd();
      send(0, 1'b0, '0);
      send(1, 1'b0, '1);
      send(2, 1'b0, shared);
      send(3, 1'b0, shared);
      send(5, 1'b0, rnd());
      send(7, 1'b0, rnd());
      send(0, 1'b1, '1);
      send(7, 1'b1, m_nom[7]);
      run_pass(1'b0);
      check_alias(10);
      check_alias(100);

      // overwrite one nominal slot and re-evaluate
      send(2, 1'b0, rnd());
      run_pass(1'b0);
      check_alias(31);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule